// File: doc/BRIEF.md
# Conditional Relative Branch Evaluator

This block resolves the eight conditional relative branch opcodes of an 8-bit processor. Each request carries the opcode byte, the four condition flags, the signed 8-bit displacement and the address that follows the two-byte branch instruction. For each request the block returns three things: whether the branch is taken, the program counter to continue from, and how many cycles the instruction costs. Any opcode that is not one of the eight branches is reported as invalid. The four flags are passed through unchanged, because a branch never modifies status.

Requests and results move as streams. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented in a one-entry output register starting on the next cycle. `in_ready` is high whenever that register is empty or is being emptied in the same cycle (`out_valid && out_ready`). As a result, a steady stream with `out_ready` held high moves one request per cycle. While `out_valid` is high and `out_ready` is low, the result is held frozen and no new request is accepted.

The branch target is the next-instruction address plus the displacement sign-extended to 16 bits. A taken branch costs one extra cycle. It costs a further cycle when the high byte of the target differs from the high byte of the next-instruction address.

Top module: `cond_branch_unit`

## Requirements
- R1: An opcode is a branch only when its low five bits are 10000 (binary). Any other opcode gives `out_invalid`=1, `out_taken`=0, `out_pc` equal to `in_next_pc` and `out_cycles`=0.
- R2: For a branch, opcode bits [7:6] select the tested flag: 00 negative, 01 overflow, 10 carry, 11 zero. The branch is taken when that flag equals opcode bit 5.
- R3: When the branch is taken, `out_pc` = `in_next_pc` + sign-extended `in_disp`, modulo 2^16. When it is not taken, `out_pc` = `in_next_pc`.
- R4: A valid branch costs 2 cycles when not taken. It costs 3 cycles when taken with the target in the same 256-byte page (same bits [15:8]) as `in_next_pc`. It costs 4 cycles when taken with the target in a different page.
- R5: `in_ready` = !`out_valid` || `out_ready`. An accepted request shows up with `out_valid`=1 on the following cycle.
- R6: While `out_valid`=1 and `out_ready`=0, every output field stays unchanged and `out_valid` stays 1.
- R7: After reset, `out_valid`=0 and `in_ready`=1.
- R8: `out_flags` equals the `in_flags` of the same request, for every opcode. The bit order is [3] negative, [2] overflow, [1] zero, [0] carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_opcode | input | 8 | Instruction opcode byte |
| in_flags | input | 4 | Flags: [3] negative, [2] overflow, [1] zero, [0] carry |
| in_disp | input | 8 | Signed displacement |
| in_next_pc | input | 16 | Address after the branch instruction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_taken | output | 1 | Branch condition met |
| out_invalid | output | 1 | Opcode is not a conditional branch |
| out_pc | output | 16 | Next program counter |
| out_cycles | output | 3 | Instruction cycle count |
| out_flags | output | 4 | Flags, unchanged |

## Verification
Two things can occur in the same cycle: the held result leaving and a new request entering. The bench provokes this by keeping `in_valid` high while `out_ready` follows a periodic pattern with two-cycle stalls. A pass-through cycle is judged correct when each result is matched against a queue of arithmetically computed expectations in acceptance order, with none lost or duplicated, and when a frozen result keeps every field during a stall. The same sweep also hits the other collision, a taken branch that also crosses a page. For that case the bench checks that both extra cycles are counted, including targets that wrap past 16'hFFFF.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int unsigned BR_FLAG_W = 4;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
    logic carry;
  } br_flags_t;

  typedef enum logic [1:0] {
    FSEL_NEG   = 2'b00,
    FSEL_OVF   = 2'b01,
    FSEL_CARRY = 2'b10,
    FSEL_ZERO  = 2'b11
  } flag_sel_e;
endpackage

// File: rtl/br_cond_decode.sv
module br_cond_decode
  import br_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  input  br_flags_t       flags,
  output logic            is_branch,
  output logic            cond_met
);
  localparam int unsigned SEL_LO = OP_W - 2;
  localparam int unsigned WANT_B = OP_W - 3;

  flag_sel_e sel;
  logic      tested;

  // Branch class: low bits fixed at 1_0000
  assign is_branch = (opcode[4:0] == 5'b10000);
  assign sel       = flag_sel_e'(opcode[OP_W-1:SEL_LO]);

  always_comb begin
    unique case (sel)
      FSEL_NEG:   tested = flags.neg;
      FSEL_OVF:   tested = flags.ovf;
      FSEL_CARRY: tested = flags.carry;
      default:    tested = flags.zero;
    endcase
  end

  assign cond_met = is_branch && (tested == opcode[WANT_B]);
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned PAGE_W = 8
) (
  input  logic [PC_W-1:0]   next_pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   target,
  output logic              page_cross
);
  localparam int unsigned EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_noext
      assign disp_ext = disp[PC_W-1:0];
    end
  endgenerate

  assign target     = next_pc + disp_ext;
  assign page_cross = (target[PC_W-1:PAGE_W] != next_pc[PC_W-1:PAGE_W]);
endmodule

// File: rtl/br_cycle_count.sv
module br_cycle_count #(
  parameter int unsigned CYC_W = 3,
  parameter int unsigned BASE  = 2
) (
  input  logic             invalid,
  input  logic             taken,
  input  logic             page_cross,
  output logic [CYC_W-1:0] cycles
);
  logic [CYC_W-1:0] extra;

  always_comb begin
    extra = '0;
    if (taken) begin
      extra = CYC_W'(1);
      if (page_cross) extra = CYC_W'(2);
    end
  end

  assign cycles = invalid ? '0 : (CYC_W'(BASE) + extra);
endmodule

// File: rtl/br_out_stage.sv
module br_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import br_pkg::*;
#(
  parameter int unsigned OP_W   = 8,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned CYC_W  = 3,
  parameter int unsigned BASE   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [OP_W-1:0]      in_opcode,
  input  logic [BR_FLAG_W-1:0] in_flags,
  input  logic [DISP_W-1:0]    in_disp,
  input  logic [PC_W-1:0]      in_next_pc,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_taken,
  output logic                 out_invalid,
  output logic [PC_W-1:0]      out_pc,
  output logic [CYC_W-1:0]     out_cycles,
  output logic [BR_FLAG_W-1:0] out_flags
);
  localparam int unsigned PAY_W = 2 + PC_W + CYC_W + BR_FLAG_W;

  logic             is_branch, cond_met, page_cross;
  logic [PC_W-1:0]  target, new_pc;
  logic [CYC_W-1:0] cycles;
  logic [PAY_W-1:0] pay_in, pay_out;

  br_cond_decode #(.OP_W(OP_W)) u_decode (
    .opcode    (in_opcode),
    .flags     (br_flags_t'(in_flags)),
    .is_branch (is_branch),
    .cond_met  (cond_met)
  );

  br_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W), .PAGE_W(PAGE_W)) u_target (
    .next_pc    (in_next_pc),
    .disp       (in_disp),
    .target     (target),
    .page_cross (page_cross)
  );

  br_cycle_count #(.CYC_W(CYC_W), .BASE(BASE)) u_cycles (
    .invalid    (!is_branch),
    .taken      (cond_met),
    .page_cross (page_cross),
    .cycles     (cycles)
  );

  assign new_pc = cond_met ? target : in_next_pc;
  assign pay_in = {cond_met, !is_branch, new_pc, cycles, in_flags};

  br_out_stage #(.W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_taken, out_invalid, out_pc, out_cycles, out_flags} = pay_out;

  p_invalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (!out_taken && out_cycles == '0));

  p_cycles_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid) |->
      (out_cycles >= CYC_W'(BASE) && out_cycles <= CYC_W'(BASE + 2)));

  p_taken_cost_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid) |-> (out_taken == (out_cycles != CYC_W'(BASE))));
endmodule

// File: tb/test_cond_branch_unit.sv
module test_cond_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [3:0]  in_flags = '0;
  logic [7:0]  in_disp = '0;
  logic [15:0] in_next_pc = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_taken, out_invalid;
  logic [15:0] out_pc;
  logic [2:0]  out_cycles;
  logic [3:0]  out_flags;

  int total = 0;
  int bad   = 0;

  localparam int NSWEEP = 4096;
  localparam int NDISP  = 512;
  localparam int NALL   = NSWEEP + NDISP;

  always #10 clk = ~clk;

  cond_branch_unit i_cond_branch_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_flags(in_flags),
    .in_disp(in_disp), .in_next_pc(in_next_pc),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_invalid(out_invalid),
    .out_pc(out_pc), .out_cycles(out_cycles), .out_flags(out_flags)
  );

  // expected record: {taken, invalid, pc, cycles, flags}
  typedef struct packed {
    logic        taken;
    logic        invalid;
    logic [15:0] pc;
    logic [2:0]  cycles;
    logic [3:0]  flags;
  } exp_t;

  exp_t q[$];

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [7:0] op, input logic [3:0] fl,
                                 input logic [7:0] d, input logic [15:0] npc);
    exp_t e;
    logic flag;
    logic [15:0] tgt;
    bit br;
    br = (op % 32) == 16;
    case (op / 64)
      0: flag = fl[3];
      1: flag = fl[2];
      2: flag = fl[0];
      default: flag = fl[1];
    endcase
    tgt = 16'(int'(npc) + int'($signed(d)));
    e.flags   = fl;
    e.invalid = !br;
    e.taken   = br && (flag == op[5]);
    e.pc      = e.taken ? tgt : npc;
    if (!br) e.cycles = 3'd0;
    else if (!e.taken) e.cycles = 3'd2;
    else if ((tgt / 256) != (npc / 256)) e.cycles = 3'd4;
    else e.cycles = 3'd3;
    return e;
  endfunction

  task automatic stim(input int idx);
    if (idx < NSWEEP) begin
      in_opcode  = 8'(idx / 16);
      in_flags   = 4'(idx % 16);
      in_next_pc = 16'(16'h00F0 + (idx / 16) * 257 + (idx % 16) * 8);
      in_disp    = 8'((idx / 16) * 37 + (idx % 16) * 11);
    end else begin
      int j = idx - NSWEEP;
      in_disp = 8'(j % 256);
      if (j < 256) begin
        in_opcode = 8'hF0; in_flags = 4'b0010; in_next_pc = 16'h1280;
      end else begin
        in_opcode = 8'h10; in_flags = 4'b0000; in_next_pc = 16'hFFC0;
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int idx = 0;
    int cyc = 0;
    bit last_in = 0;
    bit held = 0;
    bit prev_in_fire = 0;
    exp_t snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state
    check(out_valid == 1'b0, "R7 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R7 in_ready after reset", in_ready, 1);

    while (idx < NALL || in_valid || q.size() > 0) begin
      bit fin, fout;
      @(negedge clk);
      cyc++;
      if (!in_valid || last_in) begin
        if (idx < NALL) begin
          stim(idx); idx++; in_valid = 1'b1;
        end else in_valid = 1'b0;
      end
      out_ready = !((cyc % 7) == 2 || (cyc % 7) == 3);
      #1;
      // R5: result present one cycle after acceptance
      if (prev_in_fire) check(out_valid == 1'b1, "R5 out_valid after accept", out_valid, 1);
      check(in_ready == (!out_valid || out_ready), "R5 in_ready rule", in_ready, !out_valid || out_ready);
      // R6: stall holds everything
      if (held) begin
        check(out_valid && {out_taken, out_invalid, out_pc, out_cycles, out_flags} == snap,
              "R6 held result", out_pc, snap.pc);
      end
      held = out_valid && !out_ready;
      snap = {out_taken, out_invalid, out_pc, out_cycles, out_flags};
      fin  = in_valid && in_ready;
      fout = out_valid && out_ready;
      if (fout) begin
        exp_t e;
        if (q.size() == 0) begin
          check(0, "R5 unexpected result", 1, 0);
        end else begin
          e = q.pop_front();
          check(out_invalid == e.invalid, "R1 invalid flag", out_invalid, e.invalid);
          check(out_taken == e.taken, "R2 taken", out_taken, e.taken);
          check(out_pc == e.pc, "R3 next pc", out_pc, e.pc);
          check(out_cycles == e.cycles, "R4 cycle count", out_cycles, e.cycles);
          check(out_flags == e.flags, "R8 flags unchanged", out_flags, e.flags);
        end
      end
      if (fin) q.push_back(model(in_opcode, in_flags, in_disp, in_next_pc));
      last_in = fin;
      prev_in_fire = fin;
    end
    // steady stream of one per cycle when consumer always ready
    out_ready = 1'b1;
    in_valid  = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      check(in_ready == 1'b1, "R5 full throughput", in_ready, 1);
    end
    in_valid = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule